// File: doc/BRIEF.md
# Idle-Aware Data Pending Detector

This block sits in the transmit path of an upstream burst transmitter. It watches a stream of 8-bit characters, each qualified by a data/control flag, and reports whether real traffic is waiting to be sent. Every accepted character passes unchanged through a fixed-length delay line. The downstream burst controller and the FEC stage therefore see a flag that is well ahead of the characters it describes.

The pending flag rises on the first non-IDLE character that enters the line. It falls only when the most recent `WATCH` accepted characters are all IDLE. `WATCH` is derived from the sync length, the delimiter length and the count of leading IDLEs. A transmitter can therefore switch on as soon as traffic appears. It switches off only after a long run of idle has been confirmed. An input valid strobe advances the line. Cycles without the strobe change nothing.

Top module: `idle_pend_detect`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `data_pending` is 0 and `out_vld` is 0. The output character is the IDLE character: `out_ctrl`=1, `out_data`=0x07. The line is refilled with IDLE.
- R2: On a clock edge with `in_vld`=1, `out_vld` becomes 1 after that edge. `{out_ctrl,out_data}` then equals the character accepted exactly `DEPTH` valid beats earlier, or IDLE if fewer than `DEPTH` beats have been accepted since reset.
- R3: On a clock edge with `in_vld`=0, `out_vld` becomes 0. The output character, the delay-line contents and `data_pending` keep their values.
- R4: After a valid beat that carries a non-IDLE character, `data_pending` is 1 from the next cycle on.
- R5: After a valid beat that leaves the last `WATCH` accepted characters all IDLE, `data_pending` is 0 in the next cycle.
- R6: A character is IDLE only when `ctrl`=1 and `data`=0x07. A data byte 0x07 with `ctrl`=0 is non-IDLE, and so is any other control code.
- R7: `data_pending` stays 1 while any of the last `WATCH` accepted characters is non-IDLE. A single non-IDLE character surrounded by IDLEs keeps it high for exactly `WATCH` valid beats.
- R8: `WATCH` = `SYNC_CHARS` + `DELIM_CHARS` + `LEAD_IDLES`, and the defaults give 8 + 8 + 16 = 32. `DEPTH` is at least `WATCH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input strobe; a high value pushes one character |
| in_data | input | 8 | Input character byte |
| in_ctrl | input | 1 | Input control flag (1 = control character) |
| out_vld | output | 1 | A character left the line on the previous edge |
| out_data | output | 8 | Delayed character byte |
| out_ctrl | output | 1 | Delayed control flag |
| data_pending | output | 1 | Traffic pending within the watched window |

## Verification
A wrong running count in this block shows at `data_pending`. The fall comes too early, too late, or never. It is visible one cycle after the valid beat on which the window should have drained, so an isolated non-IDLE character followed by idle exposes it within `WATCH` beats. A corrupted delay-line entry or a wrong tap shows at `out_data`/`out_ctrl` exactly `DEPTH` valid beats after the character entered. A state machine that misses a rise shows on the very next cycle. Stalled cycles interleaved with traffic expose any logic that advances without the strobe.

// File: rtl/idet_pkg.sv
package idet_pkg;

  typedef struct packed {
    logic       ctrl;
    logic [7:0] data;
  } xchar_t;

  localparam logic [7:0] IDLE_CODE = 8'h07;
  localparam xchar_t     IDLE_CHAR = '{ctrl: 1'b1, data: IDLE_CODE};

  typedef enum logic {
    ST_NOPEND = 1'b0,
    ST_PEND   = 1'b1
  } pend_state_e;

  // R6: only the control code 0x07 counts as idle
  function automatic logic is_busy(input xchar_t c);
    return !(c.ctrl && (c.data == IDLE_CODE));
  endfunction

  function automatic int window_len(input int sync_c, input int delim_c, input int lead_c);
    return sync_c + delim_c + lead_c;
  endfunction

endpackage

// File: rtl/idet_delay_line.sv
module idet_delay_line
  import idet_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int WATCH = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push,
  input  xchar_t din,
  output xchar_t far_tap,
  output xchar_t tail
);

  xchar_t line [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)       line[gi] <= IDLE_CHAR;
          else if (push) line[gi] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)       line[gi] <= IDLE_CHAR;
          else if (push) line[gi] <= line[gi-1];
        end
      end
    end
  endgenerate

  // oldest character inside the watched window, leaves it on the next push
  assign far_tap = line[WATCH-1];
  assign tail    = line[DEPTH-1];

  a_r3_line_frozen: assert property (@(posedge clk) disable iff (rst)
    !push |=> ($stable(far_tap) && $stable(tail)));

  a_r2_line_shift: assert property (@(posedge clk) disable iff (rst)
    push |=> (line[0] == $past(din)));

endmodule

// File: rtl/idet_window_count.sv
module idet_window_count #(
  parameter int WATCH = 32,
  localparam int CW   = $clog2(WATCH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          busy_in,
  input  logic          busy_leave,
  output logic [CW-1:0] cnt,
  output logic          next_zero
);

  logic [CW-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt;
    if (push) cnt_next = cnt + CW'(busy_in) - CW'(busy_leave);
  end

  assign next_zero = (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_next;
  end

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WATCH));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (push && (cnt == '0)) |-> !busy_leave);

endmodule

// File: rtl/idet_pend_fsm.sv
module idet_pend_fsm
  import idet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic busy_in,
  input  logic next_zero,
  output logic pend
);

  pend_state_e state, state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_NOPEND: if (push && busy_in)   state_n = ST_PEND;
      ST_PEND:   if (push && next_zero) state_n = ST_NOPEND;
      default:   state_n = ST_NOPEND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NOPEND;
    else     state <= state_n;
  end

  assign pend = (state == ST_PEND);

  a_r4_rise: assert property (@(posedge clk) disable iff (rst)
    (push && busy_in) |=> pend);

endmodule

// File: rtl/idle_pend_detect.sv
module idle_pend_detect
  import idet_pkg::*;
#(
  parameter int SYNC_CHARS  = 8,
  parameter int DELIM_CHARS = 8,
  parameter int LEAD_IDLES  = 16,
  parameter int DEPTH       = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [7:0] in_data,
  input  logic       in_ctrl,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic       out_ctrl,
  output logic       data_pending
);

  localparam int WATCH = window_len(SYNC_CHARS, DELIM_CHARS, LEAD_IDLES);
  localparam int CW    = $clog2(WATCH + 1);

  xchar_t        din, far_tap, tail, out_q;
  logic          busy_in, busy_leave, next_zero;
  logic [CW-1:0] win_cnt;

  assign din        = '{ctrl: in_ctrl, data: in_data};
  assign busy_in    = is_busy(din);
  assign busy_leave = is_busy(far_tap);

  idet_delay_line #(.DEPTH(DEPTH), .WATCH(WATCH)) u_line (
    .clk(clk), .rst(rst), .push(in_vld), .din(din),
    .far_tap(far_tap), .tail(tail)
  );

  idet_window_count #(.WATCH(WATCH)) u_count (
    .clk(clk), .rst(rst), .push(in_vld), .busy_in(busy_in),
    .busy_leave(busy_leave), .cnt(win_cnt), .next_zero(next_zero)
  );

  idet_pend_fsm u_fsm (
    .clk(clk), .rst(rst), .push(in_vld), .busy_in(busy_in),
    .next_zero(next_zero), .pend(data_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= IDLE_CHAR;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_q <= tail;
    end
  end

  assign out_data = out_q.data;
  assign out_ctrl = out_q.ctrl;

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!data_pending && !out_vld && out_ctrl && (out_data == IDLE_CODE)));

  a_r5_link: assert property (@(posedge clk) disable iff (rst)
    data_pending == (win_cnt != '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(data_pending) && !out_vld && $stable(out_data) && $stable(out_ctrl)));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_ctrl && (in_data == 8'h07) && !data_pending) |=> !data_pending);

endmodule

// File: tb/tb_idle_pend_detect.sv
`timescale 1ns/1ps
module tb_idle_pend_detect;

  localparam int SYNC_C  = 8;
  localparam int DELIM_C = 8;
  localparam int LEAD_C  = 16;
  localparam int DEPTH   = 48;
  localparam int WATCH   = SYNC_C + DELIM_C + LEAD_C;   // R8

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_data = 8'h07;
  logic       in_ctrl = 1'b1;
  logic       out_vld, out_ctrl, data_pending;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  idle_pend_detect #(.SYNC_CHARS(SYNC_C), .DELIM_CHARS(DELIM_C),
                     .LEAD_IDLES(LEAD_C), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_vld(out_vld), .out_data(out_data), .out_ctrl(out_ctrl),
    .data_pending(data_pending)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [8:0] hist[$];
  logic       exp_vld, exp_ctrl, exp_pend, prev_pend;
  logic [7:0] exp_data;

  always @(posedge clk) cyc++;

  function automatic bit busy9(input logic [8:0] c);
    return !(c[8] == 1'b1 && c[7:0] == 8'h07);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare(input string tag);
    string ptag;
    ptag = tag;
    if (exp_pend && !prev_pend) ptag = "R4";
    if (!exp_pend && prev_pend) ptag = "R5";
    check(tag == "R1" ? "R1" : "R3", "out_vld", out_vld, exp_vld);
    check(tag == "R1" ? "R1" : "R2", "out_char", {out_ctrl, out_data}, {exp_ctrl, exp_data});
    check(ptag, "data_pending", data_pending, exp_pend);
    prev_pend = exp_pend;
  endtask

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < DEPTH; i++) hist.push_back(9'h107);
    exp_vld = 0; exp_ctrl = 1; exp_data = 8'h07; exp_pend = 0; prev_pend = 0;
  endtask

  task automatic step(input logic v, input logic c, input logic [7:0] d, input string tag);
    logic [8:0] leaving;
    @(negedge clk);
    compare(tag);
    in_vld = v; in_ctrl = c; in_data = d;
    if (v) begin
      hist.push_back({c, d});
      leaving = hist.pop_front();
      {exp_ctrl, exp_data} = leaving;
      exp_vld  = 1;
      exp_pend = 0;
      for (int i = 0; i < WATCH; i++) if (busy9(hist[DEPTH-1-i])) exp_pend = 1;
    end else begin
      exp_vld = 0;
    end
  endtask

  task automatic idles(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, 8'h07, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    step(0, 1, 8'h07, "R1");
    // R4/R7: single busy byte then exactly WATCH beats of pending
    idles(5, "R7");
    step(1, 0, 8'h55, "R4");
    idles(WATCH + 4, "R7");
    // R6: data 0x07 with ctrl 0 is busy; other control codes are busy
    step(1, 0, 8'h07, "R6");
    idles(WATCH + 2, "R6");
    step(1, 1, 8'hFB, "R6");
    idles(3, "R6");
    step(1, 1, 8'hFD, "R6");
    idles(WATCH + 2, "R5");
    // R5: burst then drain, with pending across the boundary
    for (int i = 0; i < 20; i++) step(1, 0, 8'(i * 7 + 1), "R7");
    idles(WATCH + DEPTH, "R5");
    // R3: stalls interleaved with traffic
    for (int i = 0; i < 400; i++) begin
      logic v, c; logic [7:0] d;
      v = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) < 7) begin c = 1; d = 8'h07; end
      else begin c = 1'($urandom_range(0, 1)); d = 8'($urandom_range(0, 255)); end
      step(v, c, d, "R3");
    end
    idles(WATCH + 2, "R5");
    // R2: dense random traffic with sparse idle gaps
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) step(1, 1, 8'h07, "R2");
      else step(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
                8'($urandom_range(0, 255)), "R2");
    end
    idles(DEPTH + 4, "R5");
    // R1: reset mid-traffic refills the line with idle
    step(1, 0, 8'hA5, "R2");
    @(negedge clk); rst = 1; in_vld = 0;
    @(negedge clk); rst = 0;
    model_reset();
    step(0, 1, 8'h07, "R1");
    idles(DEPTH + 2, "R1");
    step(0, 1, 8'h07, "R3");
    summary();
  end

endmodule